// File: doc/BRIEF.md
# Eight-Bit Up/Down Timer with Reload

This block is an eight-bit timer counter that sits on a small processor register bus. Software picks a count clock from a free-running prescaler on the system clock, from a divided subclock strobe, or from edges of an external event input. It also picks the count direction and whether the counter wraps freely or restarts from a reload value. Every wrap past the top or the bottom of the range raises a sticky interrupt request flag. The flag stays set until software clears it.

One bus address serves two purposes. A read returns the live count. A write stores a new reload value and also starts the counter from that value. A mode register holds the clock choice, the direction and the wrap behaviour. A flag register exposes the request bit.

Register map:
- Address 0: mode register.
- Address 1: count on read, reload on write.
- Address 2: flag register, bit 0 only.
- Address 3: always reads 0x00.

Top module: `updown_timer`

## Requirements
- R1: After reset the count reads 0x00, the flag reads 0 and the mode register reads 0x18.
- R2: A read at address 1 returns the live count. A write at address 1 sets the reload value and the count to the written byte at the same clock edge. If a count step falls on that edge, the write takes priority.
- R3: Mode bits 2:0 select the count clock. Codes 000, 001, 010, 011, 100 and 101 give one step every 8192, 2048, 512, 64, 16 and 4 system clock cycles.
- R4: Code 110 gives one step for every four pulses on the subclock strobe input.
- R5: Code 111 gives one step per edge of the event input, after a two-flop synchronizer. With edge select at 1 only rising edges count; with edge select at 0 only falling edges count.
- R6: Mode bits 6:5 set the direction. 00 and 10 count up, 01 counts down, and 11 follows the direction input (1 up, 0 down).
- R7: Counting up from 0xFF goes to 0x00 when mode bit 7 is 0, and to the reload value when mode bit 7 is 1.
- R8: Counting down from 0x00 goes to 0xFF when mode bit 7 is 0, and to the reload value when mode bit 7 is 1.
- R9: Every overflow or underflow sets the flag. The flag is read at address 2 bit 0. Writing 0 to that bit clears the flag. Writing 1 has no effect. If a wrap and a clear fall on the same edge, the set wins.
- R10: Mode bits 4:3 always read 1 and ignore writes. Bits 7:5 and 2:0 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| sub_tick | input | 1 | One-cycle strobe per subclock period |
| evt_in | input | 1 | External event input, asynchronous |
| evt_rise | input | 1 | Event edge select: 1 rising, 0 falling |
| dir_up | input | 1 | Direction input used when mode bits 6:5 are 11 |
| irq_flag | output | 1 | Sticky interrupt request flag |

## Verification
The hardest part to reach is the exact step count for a prescaler tap. The prescaler phase is never visible at the ports. The stimulus relies on one property of a periodic tick: any N·k consecutive edges contain exactly k ticks of a divide-by-N tap. So after a reload write restarts the counter, the bench waits an exact multiple of the period and expects an exact count, whatever the phase. Wraps are reached by loading values one or two steps from an end of the range. Flag clear tests first switch to the event clock with the event input held still. This freezes the counter, so a fresh wrap cannot hide a clear.

// File: rtl/updt_pkg.sv
package updt_pkg;
    localparam int CNT_W    = 8;
    localparam int ADDR_W   = 2;
    localparam int CODE_W   = 3;
    localparam int NUM_TAPS = 6;
    localparam int PRE_W    = 13;
    localparam int SUB_DIV_W = 2;

    localparam logic [ADDR_W-1:0] A_MODE  = 2'd0;
    localparam logic [ADDR_W-1:0] A_COUNT = 2'd1;
    localparam logic [ADDR_W-1:0] A_FLAG  = 2'd2;

    typedef struct packed {
        logic              reload_en;
        logic [1:0]        dir;
        logic [CODE_W-1:0] clk_code;
    } mode_t;

    // prescaler bit count behind each tap: code 0 is the slowest
    function automatic int tap_shift(input int idx);
        case (idx)
            0:       return 13;
            1:       return 11;
            2:       return 9;
            3:       return 6;
            4:       return 4;
            default: return 2;
        endcase
    endfunction
endpackage

// File: rtl/updt_prescale.sv
module updt_prescale
    import updt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sub_tick,
    output logic [NUM_TAPS-1:0] tap_tick,
    output logic                sub_step
);
    typedef struct packed {
        logic [PRE_W-1:0]     pre;
        logic [SUB_DIV_W-1:0] sub;
    } pre_st_t;

    pre_st_t st_d, st_q;

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int SH = tap_shift(g);
        assign tap_tick[g] = &st_q.pre[SH-1:0];
    end

    assign sub_step = sub_tick && (&st_q.sub);

    always_comb begin
        st_d     = st_q;
        st_d.pre = st_q.pre + 1'b1;
        if (sub_tick) st_d.sub = st_q.sub + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/updt_evt_edge.sv
module updt_evt_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_in,
    input  logic evt_rise,
    output logic evt_step
);
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } ev_st_t;

    ev_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = evt_in;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
        evt_step  = evt_rise ? (st_q.sync && !st_q.prev)
                             : (!st_q.sync && st_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/updt_core.sv
module updt_core
    import updt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             count_up,
    input  logic             reload_en,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_val,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             flag
);
    localparam logic [CNT_W-1:0] TOP = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        logic             flag;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flag_clr) st_d.flag = 1'b0;
        if (load_wr) begin
            st_d.rld = load_val;
            st_d.cnt = load_val;
        end else if (step) begin
            if (count_up) begin
                if (st_q.cnt == TOP) begin
                    st_d.cnt  = reload_en ? st_q.rld : '0;
                    st_d.flag = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                if (st_q.cnt == '0) begin
                    st_d.cnt  = reload_en ? st_q.rld : TOP;
                    st_d.flag = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign flag  = st_q.flag;
endmodule

// File: rtl/updown_timer.sv
module updown_timer
    import updt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              sub_tick,
    input  logic              evt_in,
    input  logic              evt_rise,
    input  logic              dir_up,
    output logic              irq_flag
);
    localparam int SRC_N = 2 ** CODE_W;

    mode_t mode_d, mode_q;
    logic [NUM_TAPS-1:0] tap_tick;
    logic                sub_step;
    logic                evt_step;
    logic [SRC_N-1:0]    src_vec;
    logic                step;
    logic                count_up;
    logic                load_wr;
    logic                flag_clr;
    logic [CNT_W-1:0]    count_now;

    updt_prescale u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .sub_tick (sub_tick),
        .tap_tick (tap_tick),
        .sub_step (sub_step)
    );

    updt_evt_edge u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_in   (evt_in),
        .evt_rise (evt_rise),
        .evt_step (evt_step)
    );

    always_comb begin
        mode_d = mode_q;
        if (bus_wr && bus_addr == A_MODE) begin
            mode_d.reload_en = bus_wdata[7];
            mode_d.dir       = bus_wdata[6:5];
            mode_d.clk_code  = bus_wdata[CODE_W-1:0];
        end
        load_wr  = bus_wr && (bus_addr == A_COUNT);
        flag_clr = bus_wr && (bus_addr == A_FLAG) && !bus_wdata[0];
        src_vec  = {evt_step, sub_step, tap_tick};
        step     = src_vec[mode_q.clk_code];
        case (mode_q.dir)
            2'b01:   count_up = 1'b0;
            2'b11:   count_up = dir_up;
            default: count_up = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    updt_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .count_up  (count_up),
        .reload_en (mode_q.reload_en),
        .load_wr   (load_wr),
        .load_val  (bus_wdata),
        .flag_clr  (flag_clr),
        .count     (count_now),
        .flag      (irq_flag)
    );

    always_comb begin
        case (bus_addr)
            A_MODE:  bus_rdata = {mode_q.reload_en, mode_q.dir, 2'b11, mode_q.clk_code};
            A_COUNT: bus_rdata = count_now;
            A_FLAG:  bus_rdata = {{(CNT_W-1){1'b0}}, irq_flag};
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/updt_chk.sv
module updt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic [7:0] cnt,
    input logic       flag
);
    logic load_wr;
    logic clr_wr;
    assign load_wr = bus_wr && bus_addr == 2'd1;
    assign clr_wr  = bus_wr && bus_addr == 2'd2 && !bus_wdata[0];

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> cnt == $past(bus_wdata));

    assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 8'd1 ||
                      cnt == $past(cnt) - 8'd1 || $past(cnt) == 8'hFF ||
                      $past(cnt) == 8'h00));

    assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(cnt) == 8'hFF || $past(cnt) == 8'h00));

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_wr) |=> flag);

    assert_resv_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd0) |-> bus_rdata[4:3] == 2'b11);
endmodule

bind updown_timer updt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt       (count_now),
    .flag      (irq_flag)
);

// File: tb/updown_timer_test.sv
module updown_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       sub_tick = 1'b0;
    logic       evt_in = 1'b0;
    logic       evt_rise = 1'b1;
    logic       dir_up = 1'b1;
    logic       irq_flag;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t exp_q[$];

    always #5 clk = ~clk;

    updown_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sub_tick(sub_tick),
        .evt_in(evt_in), .evt_rise(evt_rise), .dir_up(dir_up), .irq_flag(irq_flag)
    );

    // monitor: compares read data away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            n_run++;
            if (bus_rdata !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got 0x%02h expected 0x%02h", it.tag, bus_rdata, it.exp);
            end
        end
    end

    // write lands on the posedge after the call starts
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        #1;
        bus_addr = a;
        it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic evt_pulse;
        evt_in = ~evt_in; cycles(6);
        evt_in = ~evt_in; cycles(6);
    endtask

    task automatic freeze_clear;
        wr(2'd0, 8'h07);
        wr(2'd2, 8'h00);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        cycles(3); #1 rst_n = 1'b1;
        cycles(1);
        rd(2'd0, 8'h18, "R1 mode reset");
        rd(2'd1, 8'h00, "R1 count reset");
        rd(2'd2, 8'h00, "R1 flag reset");

        // R10 reserved bits
        wr(2'd0, 8'h00); rd(2'd0, 8'h18, "R10 write zeros");
        wr(2'd0, 8'hE7); rd(2'd0, 8'hFF, "R10 write ones");
        wr(2'd0, 8'h65); rd(2'd0, 8'h7D, "R10 dir field readback");

        // R2 immediate load, frozen counter
        wr(2'd0, 8'h07);
        wr(2'd1, 8'h5A); rd(2'd1, 8'h5A, "R2 load sets count");

        // R3 taps: any N*k edges hold exactly k steps
        wr(2'd0, 8'h05); wr(2'd1, 8'h30); cycles(4 * 5);
        rd(2'd1, 8'h35, "R3 div4 up");
        wr(2'd0, 8'h04); wr(2'd1, 8'h30); cycles(16 * 3);
        rd(2'd1, 8'h33, "R3 div16");
        wr(2'd0, 8'h03); wr(2'd1, 8'h30); cycles(64 * 2);
        rd(2'd1, 8'h32, "R3 div64");
        wr(2'd0, 8'h02); wr(2'd1, 8'h30); cycles(512);
        rd(2'd1, 8'h31, "R3 div512");
        wr(2'd0, 8'h01); wr(2'd1, 8'h30); cycles(2048 * 2);
        rd(2'd1, 8'h32, "R3 div2048");
        wr(2'd0, 8'h00); wr(2'd1, 8'h30); cycles(8192 * 2);
        rd(2'd1, 8'h32, "R3 div8192");

        // R6 directions
        wr(2'd0, 8'h45); wr(2'd1, 8'h30); cycles(4 * 3);
        rd(2'd1, 8'h33, "R6 dir 10 counts up");
        wr(2'd0, 8'h25); wr(2'd1, 8'h30); cycles(4 * 3);
        rd(2'd1, 8'h2D, "R6 dir 01 counts down");
        dir_up = 1'b0;
        wr(2'd0, 8'h65); wr(2'd1, 8'h20); cycles(4 * 5);
        rd(2'd1, 8'h1B, "R6 pin low counts down");
        dir_up = 1'b1;
        wr(2'd1, 8'h20); cycles(4 * 5);
        rd(2'd1, 8'h25, "R6 pin high counts up");

        // R7 overflow, free wrap then reload
        freeze_clear;
        wr(2'd0, 8'h05); wr(2'd1, 8'hFE); cycles(4 * 2);
        rd(2'd1, 8'h00, "R7 free wrap to zero");
        rd(2'd2, 8'h01, "R9 set by overflow");
        freeze_clear;
        rd(2'd2, 8'h00, "R9 cleared by write 0");
        wr(2'd0, 8'h85); wr(2'd1, 8'hFD); cycles(4 * 3);
        rd(2'd1, 8'hFD, "R7 reload on overflow");
        rd(2'd2, 8'h01, "R9 set by reload overflow");

        // R8 underflow, free wrap then reload
        freeze_clear;
        wr(2'd0, 8'h25); wr(2'd1, 8'h01); cycles(4 * 2);
        rd(2'd1, 8'hFF, "R8 free wrap to FF");
        rd(2'd2, 8'h01, "R9 set by underflow");
        freeze_clear;
        wr(2'd0, 8'hA5); wr(2'd1, 8'h02); cycles(4 * 3);
        rd(2'd1, 8'h02, "R8 reload on underflow");

        // R4 subclock: divider untouched so far
        wr(2'd0, 8'h06); wr(2'd1, 8'h40);
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #1 sub_tick = 1'b1;
            @(posedge clk); #1 sub_tick = 1'b0;
            cycles(1);
        end
        cycles(2);
        rd(2'd1, 8'h42, "R4 eight strobes give two steps");

        // R5 event edges
        evt_rise = 1'b1;
        wr(2'd0, 8'h07); wr(2'd1, 8'h10);
        repeat (3) evt_pulse;
        rd(2'd1, 8'h13, "R5 rising edges");
        evt_rise = 1'b0; cycles(2);
        repeat (2) evt_pulse;
        rd(2'd1, 8'h15, "R5 falling edges");
        evt_in = 1'b1; cycles(8);
        rd(2'd1, 8'h15, "R5 rising edge ignored in falling mode");

        // R9 flag write rules, frozen counter
        evt_rise = 1'b1; evt_in = 1'b0; cycles(8);
        wr(2'd2, 8'h00);
        wr(2'd1, 8'hFF);
        evt_pulse;
        rd(2'd1, 8'h00, "R7 event overflow");
        rd(2'd2, 8'h01, "R9 event overflow sets flag");
        wr(2'd2, 8'h01); rd(2'd2, 8'h01, "R9 write 1 has no effect");
        wr(2'd2, 8'h00); rd(2'd2, 8'h00, "R9 write 0 clears");
        rd(2'd3, 8'h00, "R2 unused address reads zero");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule